// File: doc/BRIEF.md
# Round-robin vector sequencer with rate-aware chaining

This block holds up to eight active vector operations in a circular array of slots. The issue logic inserts one operation per cycle through a valid/ready pair. Each operation carries a functional-unit tag, a packing-rate code and a total vector length in elements. A pointer visits one slot per cycle in a fixed rotation. When the pointer is on a live slot that is not stalled, the block presents one sequencing event to the downstream expander. The event carries the slot index, the unit tag, the element offset at which the event starts, and the number of elements it covers. The slot's progress then advances by that count.

Operations may be chained, and they advance at different rates: 8, 16 or 32 elements per event. A younger operation is therefore held back whenever its next event would carry it past the progress of any older operation still in the array. The guard looks only at element progress. It never compares register names, so it is conservative but cheap. An operation retires on the event that reaches its vector length, and its slot returns to the free pool once every older slot has also gone.

Top module: `vseq_rr`

## Requirements
- R1: After reset, `ins_ready` is 1 and `evt_valid` is 0.
- R2: The pointer is on slot (n mod 8) in the n-th cycle after reset is released, counting from 0. `evt_valid` can only be 1 for the slot under the pointer, and `evt_slot` shows that slot. A slot that holds no operation never raises `evt_valid`.
- R3: The rate code sets the elements per event: code 0 gives 8, code 1 gives 16, code 2 gives 32, and the reserved code 3 gives 8.
- R4: An event is withheld when the slot's progress plus the event's element count would exceed the progress of any live slot inserted before it. The unit tag plays no part in this decision. The oldest live operation is never withheld.
- R5: `evt_base` equals the slot's progress before the event, which is 0 for the first event. `evt_count` is the smaller of the rate and the elements remaining, so it is never 0.
- R6: `evt_last` is 1 exactly when `evt_base + evt_count` equals the vector length. After that event the slot raises no further events.
- R7: An insert is taken in a cycle where `ins_valid` and `ins_ready` are both 1. Inserts fill slots in circular order, starting at slot 0 after reset. `evt_unit` returns the tag given at insert. `ins_vlen` must be nonzero.
- R8: The span runs from the oldest live operation to the next free position. `ins_ready` is 0 while all eight slots of this span are held. A retired slot leaves the span one cycle after every older slot has left it, at most one slot per cycle. An insert offered while `ins_ready` is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request from issue |
| ins_ready | output | 1 | Array can take an insert |
| ins_unit | input | FUW (3) | Functional-unit tag of the new operation |
| ins_rate | input | 2 | Packing-rate code of the new operation |
| ins_vlen | input | VLW (10) | Vector length in elements, nonzero |
| evt_valid | output | 1 | Sequencing event this cycle |
| evt_slot | output | 3 | Slot issuing the event |
| evt_unit | output | FUW (3) | Unit tag of that slot |
| evt_base | output | VLW (10) | First element index covered |
| evt_count | output | 6 | Elements covered by the event |
| evt_last | output | 1 | Final event of the operation |

## Verification
The event outputs come from registered state only, so an event for the slot under the pointer is visible in that same cycle. Its effect on progress and retirement shows at the next pointer visit, eight cycles later. An operation inserted at one edge is eligible for an event from the following cycle on. `ins_ready` falls in the cycle after the insert that fills the span. It rises one cycle after the oldest slot retires. The bench keeps a requirement-level model that it steps on every rising edge, and it compares all outputs half a period after each edge. Directed runs also pin literal event sequences for a partial last event, for a fast operation held behind a slow one, and for back-pressure while full.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    // Packing-rate code stored with each operation
    typedef enum logic [1:0] {
        RATE_FULL = 2'd0,   // one element per bank per event
        RATE_PAIR = 2'd1,   // two packed elements per bank entry
        RATE_QUAD = 2'd2,   // four packed elements per bank entry
        RATE_RSVD = 2'd3    // reserved, behaves as RATE_FULL
    } rate_e;

    function automatic int rate_mult(rate_e r);
        case (r)
            RATE_PAIR: rate_mult = 2;
            RATE_QUAD: rate_mult = 4;
            default:   rate_mult = 1;
        endcase
    endfunction

endpackage

// File: rtl/vseq_rate_step.sv
// Element count and next progress for one sequencing event.
module vseq_rate_step
    import vseq_pkg::*;
#(
    parameter int BASE_ELEMS = 8,
    parameter int VLW        = 10,
    parameter int CNTW       = 6
) (
    input  rate_e            rate,
    input  logic [VLW-1:0]   prog,
    input  logic [VLW-1:0]   vlen,
    output logic [CNTW-1:0]  count,
    output logic [VLW-1:0]   prog_next,
    output logic             last
);
    localparam int SUMW = VLW + 1;

    logic [SUMW-1:0] step;
    logic [SUMW-1:0] remain;

    always_comb begin
        step   = SUMW'(BASE_ELEMS * rate_mult(rate));
        remain = {1'b0, vlen} - {1'b0, prog};
        if (remain <= step) begin
            last      = 1'b1;
            count     = CNTW'(remain);
            prog_next = vlen;
        end else begin
            last      = 1'b0;
            count     = CNTW'(step);
            prog_next = prog + VLW'(step);
        end
    end

endmodule

// File: rtl/vseq_age_guard.sv
// Conservative overtaking guard: a candidate may not move beyond the
// progress of any live slot that is older in insertion order.
module vseq_age_guard #(
    parameter int NSLOT = 8,
    parameter int VLW   = 10,
    localparam int IDXW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]          valid,
    input  logic [NSLOT-1:0][VLW-1:0] prog,
    input  logic [IDXW-1:0]           head,
    input  logic [IDXW-1:0]           cand,
    input  logic [VLW-1:0]            cand_next,
    output logic                      stall
);
    function automatic logic [IDXW:0] age_of(logic [IDXW-1:0] idx, logic [IDXW-1:0] hd);
        if (idx >= hd)
            age_of = {1'b0, idx} - {1'b0, hd};
        else
            age_of = {1'b0, idx} + (IDXW+1)'(NSLOT) - {1'b0, hd};
    endfunction

    logic [IDXW:0]      cand_age;
    logic [NSLOT-1:0]   block;

    assign cand_age = age_of(cand, head);

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        logic [IDXW:0] slot_age;
        assign slot_age = age_of(IDXW'(g), head);
        assign block[g] = valid[g] && (slot_age < cand_age) && (cand_next > prog[g]);
    end

    assign stall = |block;

endmodule

// File: rtl/vseq_rr.sv
module vseq_rr
    import vseq_pkg::*;
#(
    parameter int NSLOT      = 8,
    parameter int FUW        = 3,
    parameter int VLW        = 10,
    parameter int BASE_ELEMS = 8,
    localparam int IDXW      = $clog2(NSLOT),
    localparam int CNTW      = $clog2(BASE_ELEMS * 4 + 1),
    localparam int USEDW     = $clog2(NSLOT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [FUW-1:0]   ins_unit,
    input  logic [1:0]       ins_rate,
    input  logic [VLW-1:0]   ins_vlen,
    output logic             evt_valid,
    output logic [IDXW-1:0]  evt_slot,
    output logic [FUW-1:0]   evt_unit,
    output logic [VLW-1:0]   evt_base,
    output logic [CNTW-1:0]  evt_count,
    output logic             evt_last
);
    typedef struct packed {
        logic [NSLOT-1:0]          valid;
        logic [NSLOT-1:0][FUW-1:0] unit;
        logic [NSLOT-1:0][1:0]     rate;
        logic [NSLOT-1:0][VLW-1:0] prog;
        logic [NSLOT-1:0][VLW-1:0] vlen;
        logic [IDXW-1:0]           head;
        logic [IDXW-1:0]           tail;
        logic [IDXW-1:0]           ptr;
        logic [USEDW-1:0]          used;
    } state_t;

    state_t s_q, s_d;

    function automatic logic [IDXW-1:0] wrap_inc(logic [IDXW-1:0] i);
        wrap_inc = (i == IDXW'(NSLOT - 1)) ? '0 : i + 1'b1;
    endfunction

    // Slot under the pointer
    logic [CNTW-1:0] cur_count;
    logic [VLW-1:0]  cur_next;
    logic            cur_last;
    logic            cur_stall;
    logic            fire;
    logic            accept;
    logic            drop_head;

    vseq_rate_step #(
        .BASE_ELEMS (BASE_ELEMS),
        .VLW        (VLW),
        .CNTW       (CNTW)
    ) u_step (
        .rate      (rate_e'(s_q.rate[s_q.ptr])),
        .prog      (s_q.prog[s_q.ptr]),
        .vlen      (s_q.vlen[s_q.ptr]),
        .count     (cur_count),
        .prog_next (cur_next),
        .last      (cur_last)
    );

    vseq_age_guard #(
        .NSLOT (NSLOT),
        .VLW   (VLW)
    ) u_guard (
        .valid     (s_q.valid),
        .prog      (s_q.prog),
        .head      (s_q.head),
        .cand      (s_q.ptr),
        .cand_next (cur_next),
        .stall     (cur_stall)
    );

    assign fire      = s_q.valid[s_q.ptr] && !cur_stall;
    assign ins_ready = (s_q.used < USEDW'(NSLOT));
    assign accept    = ins_valid && ins_ready;
    assign drop_head = (s_q.used != '0) && !s_q.valid[s_q.head];

    assign evt_valid = fire;
    assign evt_slot  = s_q.ptr;
    assign evt_unit  = s_q.unit[s_q.ptr];
    assign evt_base  = s_q.prog[s_q.ptr];
    assign evt_count = cur_count;
    assign evt_last  = cur_last;

    always_comb begin
        s_d     = s_q;
        s_d.ptr = wrap_inc(s_q.ptr);
        if (fire) begin
            s_d.prog[s_q.ptr] = cur_next;
            if (cur_last)
                s_d.valid[s_q.ptr] = 1'b0;
        end
        if (accept) begin
            s_d.valid[s_q.tail] = 1'b1;
            s_d.unit[s_q.tail]  = ins_unit;
            s_d.rate[s_q.tail]  = ins_rate;
            s_d.vlen[s_q.tail]  = ins_vlen;
            s_d.prog[s_q.tail]  = '0;
            s_d.tail            = wrap_inc(s_q.tail);
        end
        if (drop_head)
            s_d.head = wrap_inc(s_q.head);
        s_d.used = s_q.used + USEDW'(accept) - USEDW'(drop_head);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // R4: the oldest live operation is never held back
    a_r4_head_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid[s_q.head] && s_q.ptr == s_q.head) |-> evt_valid);

    // R5: an event covers at least one element and stays inside the vector
    a_r5_count_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_count != '0) &&
            (({1'b0, evt_base} + (VLW+1)'(evt_count)) <= {1'b0, s_q.vlen[evt_slot]}));

    // R5: a non-final event moves progress by exactly its count
    a_r5_progress_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_last) |=>
            s_q.prog[$past(evt_slot)] == $past(evt_base) + VLW'($past(evt_count)));

    // R6: the final event frees the slot
    a_r6_last_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_last) |=> !s_q.valid[$past(evt_slot)]);

    // R8: nothing is written while the array refuses inserts
    a_r8_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_ready |=> $stable(s_q.tail));

endmodule

// File: tb/vseq_rr_bench.sv
module vseq_rr_bench;
    localparam int NS = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ins_valid;
    logic       ins_ready;
    logic [2:0] ins_unit;
    logic [1:0] ins_rate;
    logic [9:0] ins_vlen;
    logic       evt_valid;
    logic [2:0] evt_slot;
    logic [2:0] evt_unit;
    logic [9:0] evt_base;
    logic [5:0] evt_count;
    logic       evt_last;

    always #4 clk = ~clk;   // 125 MHz

    vseq_rr u_vseq_rr (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_unit(ins_unit), .ins_rate(ins_rate), .ins_vlen(ins_vlen),
        .evt_valid(evt_valid), .evt_slot(evt_slot), .evt_unit(evt_unit),
        .evt_base(evt_base), .evt_count(evt_count), .evt_last(evt_last)
    );

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    // Requirement-level model
    bit m_valid [NS];
    int m_unit  [NS];
    int m_rate  [NS];
    int m_prog  [NS];
    int m_vlen  [NS];
    int m_head, m_tail, m_ptr, m_used;
    bit e_fire, e_last, e_ready;
    int e_cnt, e_base;

    // Captured events of the current directed run
    int cap_slot [64];
    int cap_cnt  [64];
    bit cap_last [64];
    int cap_n;

    // Insert table: unit, rate code, length, idle cycles after it
    localparam int T_N = 10;
    localparam int T_UNIT [T_N] = '{1, 2, 3, 4, 5, 6, 7, 0, 2, 5};
    localparam int T_RATE [T_N] = '{0, 1, 2, 3, 2, 0, 1, 2, 0, 1};
    localparam int T_VLEN [T_N] = '{40, 64, 100, 9, 33, 1, 17, 96, 24, 50};
    localparam int T_GAP  [T_N] = '{0, 0, 3, 0, 1, 0, 0, 5, 0, 2};

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int age(int i);
        return (i - m_head + NS) % NS;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_valid[i] = 0; m_unit[i] = 0; m_rate[i] = 0; m_prog[i] = 0; m_vlen[i] = 0;
        end
        m_head = 0; m_tail = 0; m_ptr = 0; m_used = 0;
    endtask

    task automatic model_eval();
        int p, stepn, rem, nxt;
        p = m_ptr;
        stepn = 8 * ((m_rate[p] == 1) ? 2 : (m_rate[p] == 2) ? 4 : 1);
        rem = m_vlen[p] - m_prog[p];
        e_cnt  = (rem <= stepn) ? rem : stepn;
        e_last = (rem <= stepn);
        e_base = m_prog[p];
        nxt = m_prog[p] + e_cnt;
        e_fire = m_valid[p];
        for (int o = 0; o < NS; o++)
            if (m_valid[o] && age(o) < age(p) && nxt > m_prog[o]) e_fire = 0;
        e_ready = (m_used < NS);
    endtask

    task automatic model_update(bit v, int u, int r, int l);
        bit drop, acc;
        drop = (m_used > 0) && !m_valid[m_head];
        acc  = v && e_ready;
        if (e_fire) begin
            m_prog[m_ptr] += e_cnt;
            if (e_last) m_valid[m_ptr] = 0;
        end
        if (acc) begin
            m_valid[m_tail] = 1; m_unit[m_tail] = u; m_rate[m_tail] = r;
            m_vlen[m_tail] = l; m_prog[m_tail] = 0;
            m_tail = (m_tail + 1) % NS;
        end
        if (drop) m_head = (m_head + 1) % NS;
        m_used = m_used + int'(acc) - int'(drop);
        m_ptr = (m_ptr + 1) % NS;
    endtask

    // Called half a period after an edge: compare, drive, cross the edge.
    task automatic step(bit v, int u, int r, int l, output bit taken);
        model_eval();
        chk(ins_ready == e_ready, "R8 ins_ready", ins_ready, e_ready);
        chk(evt_valid == e_fire, "R4 evt_valid", evt_valid, e_fire);
        if (evt_valid && e_fire) begin
            chk(evt_slot == m_ptr, "R2 evt_slot", evt_slot, m_ptr);
            chk(evt_unit == m_unit[m_ptr], "R7 evt_unit", evt_unit, m_unit[m_ptr]);
            chk(evt_base == e_base, "R5 evt_base", evt_base, e_base);
            chk(evt_count == e_cnt, "R3 evt_count", evt_count, e_cnt);
            chk(evt_last == e_last, "R6 evt_last", evt_last, e_last);
        end
        if (evt_valid && cap_n < 64) begin
            cap_slot[cap_n] = evt_slot; cap_cnt[cap_n] = evt_count;
            cap_last[cap_n] = evt_last; cap_n++;
        end
        taken = v && e_ready;
        ins_valid = v; ins_unit = 3'(u); ins_rate = 2'(r); ins_vlen = 10'(l);
        @(posedge clk);
        model_update(v, u, r, l);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        bit t;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, t);
    endtask

    task automatic push(int u, int r, int l);
        bit t;
        t = 0;
        while (!t) step(1, u, r, l, t);
    endtask

    task automatic drain();
        int k;
        k = 0;
        while ((m_used > 0) && (k < 4000)) begin idle(1); k++; end
        chk(m_used == 0, "R6 drain", m_used, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ins_valid = 0; ins_unit = 0; ins_rate = 0; ins_vlen = 0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        chk(ins_ready == 1'b1, "R1 ready after reset", ins_ready, 1);
        chk(evt_valid == 1'b0, "R1 no event after reset", evt_valid, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        bit t;
        cap_n = 0;
        @(negedge clk);
        do_reset();

        // R2: first insert lands in slot 0, first event when pointer returns to 0
        cap_n = 0;
        push(3, 0, 8);
        idle(9);
        chk(cap_n == 1, "R2 single event", cap_n, 1);
        chk(cap_slot[0] == 0, "R7 first slot", cap_slot[0], 0);
        chk(cap_cnt[0] == 8 && cap_last[0], "R6 short op", cap_cnt[0], 8);
        drain();

        // Table walk
        for (int i = 0; i < T_N; i++) begin
            push(T_UNIT[i], T_RATE[i], T_VLEN[i]);
            idle(T_GAP[i]);
        end
        drain();

        // R3 / R5: partial final event (length 20 at rate 16 -> 16 then 4)
        cap_n = 0;
        push(2, 1, 20);
        drain();
        chk(cap_n == 2, "R3 partial event count", cap_n, 2);
        chk(cap_cnt[0] == 16, "R3 pair rate", cap_cnt[0], 16);
        chk(cap_cnt[1] == 4 && cap_last[1], "R5 partial tail", cap_cnt[1], 4);

        // R4: quad-rate op behind slower full-rate op of the same unit
        cap_n = 0;
        push(1, 0, 16);
        push(1, 2, 32);
        drain();
        chk(cap_n == 3, "R4 event total", cap_n, 3);
        chk(cap_cnt[0] == 8 && cap_cnt[1] == 8 && cap_last[1], "R4 older first", cap_cnt[1], 8);
        chk(cap_cnt[2] == 32 && cap_last[2], "R4 younger after retire", cap_cnt[2], 32);
        chk(cap_slot[2] != cap_slot[0], "R4 younger slot differs", cap_slot[2], cap_slot[0] + 1);

        // R8: fill all eight slots, then offer a ninth insert while full
        for (int i = 0; i < NS; i++) push(i, 0, 64);
        chk(ins_ready == 1'b0, "R8 full", ins_ready, 0);
        step(1, 7, 2, 5, t);
        chk(t == 0, "R8 dropped insert", t, 0);
        idle(20);
        chk(ins_ready == 1'b0, "R8 still full", ins_ready, 0);
        drain();
        chk(ins_ready == 1'b1, "R8 ready after drain", ins_ready, 1);

        // R1: reset with operations in flight
        push(4, 1, 200);
        push(5, 2, 300);
        idle(10);
        do_reset();
        idle(16);
        chk(evt_valid == 1'b0, "R1 reset clears slots", evt_valid, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule